// File: doc/BRIEF.md
# Power-Fail Write-Protect Gate

This block sits between a host port of the asynchronous static RAM kind and a storage array. The host side has an active-low chip enable, output enable and write enable, plus an address and write data. The gate decides, cycle by cycle, whether a host access reaches the array, is ignored, or is blocked. It bases that decision on three digital supply-status flags. Comparators outside the block produce them, and they arrive already synchronized: supply above the deselect threshold, supply above the battery switchover threshold, and battery low. The read data bus is modelled as a data value plus a drive flag, and drive low means high impedance.

A supply state machine has five states. BACKUP: supply below switchover. DESEL: supply above switchover but below the deselect threshold. RECOVER: a hold-off count after the supply comes back. NORMAL. LAG: the worst-case delay before protection takes hold after the supply drops. Its transitions are as follows:
- BACKUP to DESEL when switchover is regained.
- DESEL to BACKUP when switchover is lost.
- DESEL to RECOVER when the supply rises above deselect. The battery flag is sampled on this transition.
- RECOVER to NORMAL once the count expires.
- RECOVER to DESEL or BACKUP when the supply drops again.
- NORMAL to LAG, or straight to DESEL when the lag is zero, when the supply drops.
- LAG back to NORMAL when the supply returns.
- LAG to DESEL once the lag expires.

A battery-not-OK flag is set when the sample shows a low battery. It vetoes the first host write that follows, then clears itself.

Top module: `pfwp_gate`

## Requirements
- R1: With chip enable high, the block never drives the read bus and never writes the array, whatever the other controls are.
- R2: While access is enabled, the controls decode as follows. Chip enable low with write enable low is a write: the array write strobe is set and the bus is not driven. Chip enable low with write enable high and output enable low is a read: the bus is driven with the array data. Chip enable low with both output enable and write enable high leaves the bus undriven.
- R3: In the deselected, recovering and backup modes, no array write occurs and the bus is not driven. The array address and write data are held at zero, so host inputs have no effect.
- R4: The mode output uses 0 = normal, 1 = deselected, 2 = recovering, 3 = backup. It reads 3 one cycle after the switchover flag falls while deselected, and 1 one cycle after the flag returns.
- R5: After the supply-good flag rises, the mode reads recovering for exactly REC_CYC cycles and then normal. REC_CYC is CLK_MHZ times REC_US.
- R6: If the supply-good flag falls during recovery, the mode returns to deselected at the next cycle. The next rise runs a full REC_CYC recovery again.
- R7: The battery-low input is sampled once, on entry to recovery. The battery-not-OK output equals that sample from the next cycle on.
- R8: While battery-not-OK is set, a write access does not change the array. The flag clears in the cycle after that write access ends, and the next write reaches the array.
- R9: After the supply-good flag falls in normal mode, accesses still pass for LAG_CYC cycles, where LAG_CYC is CLK_MHZ times LAG_NS over 1000, rounded up. The mode still reads normal during that time. If the flag returns within that time, normal operation simply continues.
- R10: A write held across the moment deselect takes hold has its array strobe removed in that same cycle.
- R11: After reset the mode reads deselected, battery-not-OK is clear, and nothing is driven or written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sup_ok | input | 1 | Supply above deselect threshold (synchronized) |
| sup_sw_ok | input | 1 | Supply above battery switchover threshold (synchronized) |
| batt_low | input | 1 | Battery below its minimum (synchronized) |
| host_ce_n | input | 1 | Host chip enable, active low |
| host_oe_n | input | 1 | Host output enable, active low |
| host_we_n | input | 1 | Host write enable, active low |
| host_addr | input | ADDR_W | Host address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Read data toward host, zero when not driven |
| host_drive | output | 1 | Read bus drive enable; low means high impedance |
| arr_addr | output | ADDR_W | Array address |
| arr_wdata | output | DATA_W | Array write data |
| arr_we | output | 1 | Array write strobe, one array write per cycle |
| arr_rdata | input | DATA_W | Array read data |
| mode | output | 2 | Operating mode code |
| batt_nok | output | 1 | Battery-not-OK flag |

## Verification
Two functions can act on the same host write in the same cycle: the supply lag expiring into deselect, and the array write strobe. The bench holds one write steady while it drops the supply-good flag. It then checks the strobe still present after exactly LAG_CYC cycles, with the mode still normal. One cycle later it checks the strobe gone and the mode deselected. A second overlap is a write against the battery veto at the first write after recovery. That case is judged by reading the location back unchanged and by the flag clearing one cycle after the write ends.

// File: rtl/pfwp_pkg.sv
`timescale 1ns/1ps
package pfwp_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL  = 2'd0,
        MODE_DESEL   = 2'd1,
        MODE_RECOVER = 2'd2,
        MODE_BACKUP  = 2'd3
    } mode_t;

    typedef enum logic [2:0] {
        ST_DESEL,
        ST_BACKUP,
        ST_RECOVER,
        ST_NORMAL,
        ST_LAG
    } sup_st_t;

    typedef enum logic [2:0] {
        ACC_OFF,
        ACC_STANDBY,
        ACC_READ,
        ACC_WRITE,
        ACC_HIZ
    } acc_t;

    function automatic int us_to_cyc(input int mhz, input int us);
        return mhz * us;
    endfunction

    function automatic int ns_to_cyc(input int mhz, input int ns);
        return (mhz * ns + 999) / 1000;
    endfunction

endpackage

// File: rtl/pfwp_supply_fsm.sv
`timescale 1ns/1ps
module pfwp_supply_fsm
    import pfwp_pkg::*;
#(
    parameter int REC_CYC = 8000000,
    parameter int LAG_CYC = 40000
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sup_ok,
    input  logic  sup_sw_ok,
    output mode_t mode_o,
    output logic  access_en_o,
    output logic  sample_o
);

    localparam int MAXC = (REC_CYC > LAG_CYC) ? REC_CYC : LAG_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] REC_LAST = CW'(REC_CYC - 1);
    localparam logic [CW-1:0] LAG_LAST = CW'((LAG_CYC > 0) ? LAG_CYC - 1 : 0);

    sup_st_t         st_q, st_d, fall_st;
    logic [CW-1:0]   cnt_q;

    // a zero lag collapses the drop path straight into deselect
    generate
        if (LAG_CYC == 0) begin : g_nolag
            assign fall_st = ST_DESEL;
        end else begin : g_lag
            assign fall_st = ST_LAG;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_BACKUP: begin
                if (sup_sw_ok) st_d = ST_DESEL;
            end
            ST_DESEL: begin
                if (!sup_sw_ok)  st_d = ST_BACKUP;
                else if (sup_ok) st_d = ST_RECOVER;
            end
            ST_RECOVER: begin
                if (!sup_ok)                st_d = sup_sw_ok ? ST_DESEL : ST_BACKUP;
                else if (cnt_q == REC_LAST) st_d = ST_NORMAL;
            end
            ST_NORMAL: begin
                if (!sup_ok) st_d = fall_st;
            end
            ST_LAG: begin
                if (sup_ok)                 st_d = ST_NORMAL;
                else if (cnt_q == LAG_LAST) st_d = ST_DESEL;
            end
            default: st_d = ST_DESEL;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_DESEL;
        end else begin
            st_q <= st_d;
        end
    end

    // dwell counter, cleared on every state change
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (st_d != st_q) begin
            cnt_q <= '0;
        end else if (st_q == ST_RECOVER || st_q == ST_LAG) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        mode_o      = MODE_DESEL;
        access_en_o = 1'b0;
        unique case (st_q)
            ST_BACKUP:  mode_o = MODE_BACKUP;
            ST_DESEL:   mode_o = MODE_DESEL;
            ST_RECOVER: mode_o = MODE_RECOVER;
            ST_NORMAL, ST_LAG: begin
                mode_o      = MODE_NORMAL;
                access_en_o = 1'b1;
            end
            default:    mode_o = MODE_DESEL;
        endcase
        sample_o = (st_q == ST_DESEL) && (st_d == ST_RECOVER);
    end

endmodule

// File: rtl/pfwp_batt_flag.sv
`timescale 1ns/1ps
module pfwp_batt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic sample,
    input  logic batt_low,
    input  logic en,
    input  logic wr_act,
    output logic nok
);

    logic wr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nok  <= 1'b0;
            wr_q <= 1'b0;
        end else begin
            wr_q <= wr_act;
            if (sample) begin
                nok <= batt_low;
            end else if (nok && en && wr_q && !wr_act) begin
                // vetoed write finished while access still enabled
                nok <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pfwp_access.sv
`timescale 1ns/1ps
module pfwp_access
    import pfwp_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              en,
    input  logic              veto,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic              arr_we,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_drive,
    output logic              wr_act
);

    acc_t acc;

    always_comb begin
        if (!en)        acc = ACC_OFF;
        else if (ce_n)  acc = ACC_STANDBY;
        else if (!we_n) acc = ACC_WRITE;
        else if (!oe_n) acc = ACC_READ;
        else            acc = ACC_HIZ;
    end

    always_comb begin
        arr_addr   = '0;
        arr_wdata  = '0;
        arr_we     = 1'b0;
        host_rdata = '0;
        host_drive = 1'b0;
        wr_act     = 1'b0;
        unique case (acc)
            ACC_READ: begin
                arr_addr   = addr;
                host_rdata = arr_rdata;
                host_drive = 1'b1;
            end
            ACC_WRITE: begin
                arr_addr  = addr;
                arr_wdata = wdata;
                arr_we    = !veto;
                wr_act    = 1'b1;
            end
            ACC_HIZ:     arr_addr = addr;
            ACC_STANDBY: arr_addr = '0;
            ACC_OFF:     arr_addr = '0;
            default:     arr_addr = '0;
        endcase
    end

endmodule

// File: rtl/pfwp_gate.sv
`timescale 1ns/1ps
module pfwp_gate
    import pfwp_pkg::*;
#(
    parameter int ADDR_W  = 15,
    parameter int DATA_W  = 8,
    parameter int CLK_MHZ = 200,
    parameter int REC_US  = 40000,
    parameter int LAG_NS  = 200000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sup_ok,
    input  logic              sup_sw_ok,
    input  logic              batt_low,
    input  logic              host_ce_n,
    input  logic              host_oe_n,
    input  logic              host_we_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_drive,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic              arr_we,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [1:0]        mode,
    output logic              batt_nok
);

    localparam int REC_CYC = us_to_cyc(CLK_MHZ, REC_US);
    localparam int LAG_CYC = ns_to_cyc(CLK_MHZ, LAG_NS);

    mode_t mode_s;
    logic  access_en;
    logic  sample;
    logic  wr_act;

    pfwp_supply_fsm #(
        .REC_CYC (REC_CYC),
        .LAG_CYC (LAG_CYC)
    ) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sup_ok      (sup_ok),
        .sup_sw_ok   (sup_sw_ok),
        .mode_o      (mode_s),
        .access_en_o (access_en),
        .sample_o    (sample)
    );

    pfwp_batt_flag flag_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample   (sample),
        .batt_low (batt_low),
        .en       (access_en),
        .wr_act   (wr_act),
        .nok      (batt_nok)
    );

    pfwp_access #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) acc_i (
        .en         (access_en),
        .veto       (batt_nok),
        .ce_n       (host_ce_n),
        .oe_n       (host_oe_n),
        .we_n       (host_we_n),
        .addr       (host_addr),
        .wdata      (host_wdata),
        .arr_rdata  (arr_rdata),
        .arr_addr   (arr_addr),
        .arr_wdata  (arr_wdata),
        .arr_we     (arr_we),
        .host_rdata (host_rdata),
        .host_drive (host_drive),
        .wr_act     (wr_act)
    );

    assign mode = mode_s;

endmodule

// File: rtl/pfwp_checker.sv
`timescale 1ns/1ps
module pfwp_checker
    import pfwp_pkg::*;
#(
    parameter int REC_CYC = 8000000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sup_sw_ok,
    input logic       host_ce_n,
    input logic       host_we_n,
    input logic       host_drive,
    input logic       arr_we,
    input logic [1:0] mode,
    input logic       batt_nok
);

    int rec_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    rec_run <= 0;
        else if (mode == MODE_RECOVER) rec_run <= rec_run + 1;
        else                           rec_run <= 0;
    end

    a_r1_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        host_ce_n |-> (!host_drive && !arr_we));

    a_r2_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !host_we_n |-> !host_drive);

    a_r3_protected_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_NORMAL) |-> (!arr_we && !host_drive));

    a_r4_backup_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BACKUP && $past(mode) != MODE_BACKUP) |-> $past(!sup_sw_ok));

    a_r5_recovery_length: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_NORMAL && $past(mode) == MODE_RECOVER) |-> (rec_run == REC_CYC));

    a_r8_veto_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        batt_nok |-> !arr_we);

    a_r8_clear_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(batt_nok) && mode == MODE_NORMAL) |-> $past(!host_ce_n && !host_we_n, 2));

endmodule

bind pfwp_gate pfwp_checker #(.REC_CYC(REC_CYC)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sup_sw_ok  (sup_sw_ok),
    .host_ce_n  (host_ce_n),
    .host_we_n  (host_we_n),
    .host_drive (host_drive),
    .arr_we     (arr_we),
    .mode       (mode),
    .batt_nok   (batt_nok)
);

// File: tb/pfwp_gate_tb.sv
`timescale 1ns/1ps
module pfwp_gate_tb_top;

    localparam int AW      = 8;
    localparam int DW      = 8;
    localparam int MHZ     = 200;
    localparam int REC_US  = 1;
    localparam int LAG_NS  = 50;
    localparam int REC_CYC = MHZ * REC_US;            // 200
    localparam int LAG_CYC = (MHZ * LAG_NS + 999) / 1000; // 10

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sup_ok = 1'b0, sup_sw_ok = 1'b1, batt_low = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] host_rdata, arr_wdata, arr_rdata;
    logic [AW-1:0] arr_addr;
    logic          host_drive, arr_we, batt_nok;
    logic [1:0]    mode;

    logic [DW-1:0] mem [0:(1<<AW)-1];

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    pfwp_gate #(
        .ADDR_W (AW), .DATA_W (DW), .CLK_MHZ (MHZ), .REC_US (REC_US), .LAG_NS (LAG_NS)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .sup_ok (sup_ok), .sup_sw_ok (sup_sw_ok),
        .batt_low (batt_low), .host_ce_n (ce_n), .host_oe_n (oe_n), .host_we_n (we_n),
        .host_addr (addr), .host_wdata (wdata), .host_rdata (host_rdata),
        .host_drive (host_drive), .arr_addr (arr_addr), .arr_wdata (arr_wdata),
        .arr_we (arr_we), .arr_rdata (arr_rdata), .mode (mode), .batt_nok (batt_nok)
    );

    // array model
    assign arr_rdata = mem[arr_addr];
    always @(posedge clk) if (arr_we) mem[arr_addr] <= arr_wdata;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d, output logic strobe);
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; wdata = d;
        #1 strobe = arr_we;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_read(input logic [AW-1:0] a, output logic drv, output logic [DW-1:0] d);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
        #1 drv = host_drive; d = host_rdata;
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic t_reset_state();
        chk(mode == 2'd1, "R11 mode after reset", mode, 1);
        chk(batt_nok == 1'b0, "R11 flag after reset", batt_nok, 0);
        chk(!host_drive && !arr_we, "R11 quiet after reset", {host_drive, arr_we}, 0);
    endtask

    task automatic t_powerup(input logic b);
        @(negedge clk);
        sup_ok = 1'b1; batt_low = b;
        @(posedge clk); @(negedge clk);
        batt_low = ~b;   // later values must not matter: sampled once
        chk(mode == 2'd2, "R5 recovering entered", mode, 2);
        chk(batt_nok == b, "R7 flag sampled", batt_nok, b);
        repeat (REC_CYC - 1) @(posedge clk);
        @(negedge clk);
        chk(mode == 2'd2, "R5 still recovering at REC_CYC", mode, 2);
        chk(batt_nok == b, "R7 single sample", batt_nok, b);
        @(posedge clk); @(negedge clk);
        batt_low = 1'b0;
        chk(mode == 2'd0, "R5 normal after REC_CYC", mode, 0);
    endtask

    task automatic t_battery_veto();
        logic s; logic dv; logic [DW-1:0] d;
        t_write(8'd5, 8'hAA, s);
        chk(s == 1'b0, "R8 first write vetoed", s, 0);
        chk(batt_nok == 1'b0, "R8 flag cleared after write", batt_nok, 0);
        t_read(8'd5, dv, d);
        chk(dv && d == (8'd5 ^ 8'h5A), "R8 array unchanged", d, 8'd5 ^ 8'h5A);
        t_write(8'd5, 8'hAA, s);
        chk(s == 1'b1, "R8 second write passes", s, 1);
        t_read(8'd5, dv, d);
        chk(dv && d == 8'hAA, "R2 read back written data", d, 8'hAA);
    endtask

    task automatic t_decode();
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b0; oe_n = 1'b0; addr = 8'd7;
        #1 chk(!host_drive && !arr_we, "R1 standby quiet", {host_drive, arr_we}, 0);
        ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b1;
        #0.5 chk(!host_drive && !arr_we, "R2 both high leaves bus undriven", {host_drive, arr_we}, 0);
        we_n = 1'b0; oe_n = 1'b0;
        #0.5 chk(!host_drive && arr_we, "R2 write with oe low", {host_drive, arr_we}, 2'b01);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic t_lag_abort();
        logic dv; logic [DW-1:0] d;
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; addr = 8'd9; wdata = 8'h3C;
        sup_ok = 1'b0;
        repeat (LAG_CYC) @(posedge clk);
        @(negedge clk);
        chk(mode == 2'd0 && arr_we, "R9 access passes during lag", {mode, arr_we}, 3'b001);
        @(posedge clk); @(negedge clk);
        chk(mode == 2'd1, "R3 deselected after lag", mode, 1);
        chk(arr_we == 1'b0, "R10 held write aborted", arr_we, 0);
        chk(arr_addr == '0, "R3 address ignored", arr_addr, 0);
        ce_n = 1'b1; we_n = 1'b1;
        t_read(8'd9, dv, d);
        chk(!dv, "R3 read not driven while deselected", dv, 0);
    endtask

    task automatic t_backup();
        @(negedge clk);
        sup_sw_ok = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(mode == 2'd3, "R4 backup mode", mode, 3);
        sup_sw_ok = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(mode == 2'd1, "R4 back to deselected", mode, 1);
    endtask

    task automatic t_lag_cancel();
        logic dv; logic [DW-1:0] d;
        @(negedge clk);
        sup_ok = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        sup_ok = 1'b1;
        repeat (LAG_CYC + 5) @(posedge clk);
        @(negedge clk);
        chk(mode == 2'd0, "R9 short dip cancels deselect", mode, 0);
        t_read(8'd9, dv, d);
        chk(dv && d == 8'h3C, "R9 write during lag reached array", d, 8'h3C);
    endtask

    task automatic t_restart();
        @(negedge clk);
        sup_ok = 1'b0;
        repeat (LAG_CYC + 1) @(posedge clk);
        @(negedge clk);
        chk(mode == 2'd1, "R3 deselected again", mode, 1);
        sup_ok = 1'b1;
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk(mode == 2'd2, "R6 mid recovery", mode, 2);
        sup_ok = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(mode == 2'd1, "R6 drop during recovery deselects", mode, 1);
        t_powerup(1'b0);   // R6 full length again
    endtask

    initial begin
        for (int i = 0; i < (1 << AW); i++) mem[i] = DW'(i) ^ 8'h5A;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1 t_reset_state();
        t_powerup(1'b1);
        t_battery_veto();
        t_decode();
        t_lag_abort();
        t_backup();
        t_powerup(1'b0);
        t_lag_cancel();
        t_restart();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule